// File: doc/BRIEF.md
# Audio Automatic Level Control Engine

This block closes a digital level-control loop around a programmable-gain input amplifier. On every sample strobe it takes the signed left and right samples and forms the magnitude of the channel or channels under control. It compares that magnitude with a programmable target level and moves a 6-bit gain code one step at a time. The gain is lowered at a paced rate while the signal is too loud. It is raised at a slower paced rate once the signal has stayed quiet for a programmable hold time.

All timing is counted in sample strobes. Each time setting doubles per code step: the hold time, the step time for raising gain (decay) and the step time for lowering gain (attack). The decay and attack settings saturate at code 10. An optional zero-crossing mode delays each gain change until the controlled signal changes sign. A fixed timeout still applies the change when a DC offset keeps the signal from crossing. A mode input picks which channels the loop drives. A channel that the loop does not drive takes its gain from a manual input.

Top module: `alc_engine`

## Requirements
- R1: Mode code 00 sends the manual gains to both outputs and freezes the loop state. Code 01 drives only the right output from the loop and measures the right sample. Code 10 drives only the left output from the loop and measures the left sample. Code 11 drives both outputs from the loop. An output the loop does not drive carries its manual gain.
- R2: A gain-limit code m caps the loop gain code at 8*m+7, so code 7 allows code 63 (+30 dB) and code 0 allows code 7 (-12 dB). Raising steps stop at the cap.
- R3: The threshold for target code t is floor((2^(W-1)-1) * F(t) / 65536), where F(15) = 32846 (-6 dBFS) and F(11) = 16462 (-12 dBFS), with 1.5 dB per code. A magnitude above the threshold is "over". A magnitude equal to or above it is "at target".
- R4: The attack interval is A = ATTACK_UNIT * 2^min(a,10) strobes. It is counted from the first active strobe. At the end of each interval, the gain code drops by one if any strobe in that interval was over.
- R5: With hold length H = 0 for hold code 0 and HOLD_UNIT * 2^(h-1) otherwise, and decay interval D = DECAY_UNIT * 2^min(d,10), the gain rises by one on the (H+D)-th consecutive strobe that is not at target. It then rises again every further D such strobes.
- R6: Decay and attack codes of 10 and above all give the interval of code 10.
- R7: A strobe at target, including one exactly equal to the threshold, restarts the hold and decay count. A strobe exactly equal to the threshold does not count as over.
- R8: The gain code never drops below 0 (-17.25 dB).
- R9: With zero-crossing mode off, a loop gain change appears on the outputs at the same clock edge that registers the strobe.
- R10: With zero-crossing mode on, the applied gain takes the loop gain only on a strobe whose sample sign bit differs from the previous strobe's sign bit. The sign is taken from the left channel in modes 10 and 11 and from the right channel in mode 01.
- R11: With zero-crossing mode on, a pending change is applied on the ZC_TIMEOUT-th strobe after it became pending, with or without a crossing.
- R12: In mode 11 the measured magnitude is the larger of the two channel magnitudes.
- R13: After reset, both the loop gain and the applied gain are code INIT_GAIN (default 23, 0 dB).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_strobe | input | 1 | One-cycle pulse marking a new sample pair |
| smp_left | input | SAMPLE_W | Signed left sample |
| smp_right | input | SAMPLE_W | Signed right sample |
| cfg_mode | input | 2 | Channel mode select |
| cfg_zc_en | input | 1 | Zero-crossing update enable |
| cfg_max_gain | input | 3 | Gain ceiling code |
| cfg_target | input | 4 | Target level code |
| cfg_hold | input | 4 | Hold time code |
| cfg_decay | input | 4 | Gain-raise step time code |
| cfg_attack | input | 4 | Gain-lower step time code |
| man_gain_left | input | 6 | Manual left gain code |
| man_gain_right | input | 6 | Manual right gain code |
| gain_left | output | 6 | Left amplifier gain code |
| gain_right | output | 6 | Right amplifier gain code |

## Verification
The loop is driven with alternating-sign square bursts at several amplitudes. Bursts well above the target separate a correct attack rate from a wrong interval, and long runs show the floor. Bursts well below the target separate hold from decay timing and expose the gain cap and the saturated decay and attack codes. Samples exactly at the threshold and one count above it separate the at-target and over comparisons. Unequal left and right amplitudes show which channel each mode measures. Constant-sign (DC) runs with zero-crossing mode on separate gating on a sign change from the timeout fallback.

// File: rtl/alc_pkg.sv
package alc_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'b00,
      MODE_RIGHT = 2'b01,
      MODE_LEFT  = 2'b10,
      MODE_BOTH  = 2'b11
   } alc_mode_e;

   localparam int GAIN_CODE_W = 6;

   // Fraction of full scale (Q16) for each target code, 1.5 dB apart.
   function automatic logic [15:0] target_frac(input logic [3:0] code);
      case (code)
         4'd0:  return 16'd2463;
         4'd1:  return 16'd2927;
         4'd2:  return 16'd3479;
         4'd3:  return 16'd4135;
         4'd4:  return 16'd4915;
         4'd5:  return 16'd5841;
         4'd6:  return 16'd6942;
         4'd7:  return 16'd8250;
         4'd8:  return 16'd9806;
         4'd9:  return 16'd11654;
         4'd10: return 16'd13851;
         4'd11: return 16'd16462;
         4'd12: return 16'd19565;
         4'd13: return 16'd23253;
         4'd14: return 16'd27636;
         default: return 16'd32846;
      endcase
   endfunction

   // Gain ceiling: limit code m maps to gain code 8*m+7.
   function automatic logic [GAIN_CODE_W-1:0] ceiling_code(input logic [2:0] m);
      return {m, 3'b111};
   endfunction

   function automatic int timer_width(input longint a, input longint b, input longint c);
      longint m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return $clog2(m + 1);
   endfunction

endpackage

// File: rtl/alc_level_detect.sv
module alc_level_detect import alc_pkg::*; #(
   parameter int SAMPLE_W = 16
) (
   input  logic [SAMPLE_W-1:0] smp_l,
   input  logic [SAMPLE_W-1:0] smp_r,
   input  alc_mode_e           mode,
   input  logic [SAMPLE_W-1:0] thr,
   output logic                at_target,
   output logic                over,
   output logic                sign_bit
);
   logic [SAMPLE_W-1:0] mag [2];
   logic [SAMPLE_W-1:0] mag_sel;

   for (genvar c = 0; c < 2; c++) begin : g_abs
      logic [SAMPLE_W-1:0] raw;
      assign raw    = (c == 0) ? smp_l : smp_r;
      assign mag[c] = raw[SAMPLE_W-1] ? (~raw + 1'b1) : raw;
   end

   always_comb begin
      case (mode)
         MODE_RIGHT: mag_sel = mag[1];
         MODE_LEFT:  mag_sel = mag[0];
         default:    mag_sel = (mag[0] > mag[1]) ? mag[0] : mag[1];
      endcase
   end

   assign at_target = (mag_sel >= thr);
   assign over      = (mag_sel > thr);
   assign sign_bit  = (mode == MODE_RIGHT) ? smp_r[SAMPLE_W-1] : smp_l[SAMPLE_W-1];

   // R7: anything over the threshold is also at target
   always_comb begin
      a_over_implies_hit_r7: assert (!over || at_target);
   end
endmodule

// File: rtl/alc_step_timer.sv
module alc_step_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [CNT_W-1:0] len,
   output logic             tick
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q >= len - 1'b1);
   assign tick   = adv && !clr && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (clr)        cnt_q <= '0;
      else if (adv) begin
         if (at_end)       cnt_q <= '0;
         else              cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4/R5: count resets after every tick
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt_q == '0))
      else $error("timer did not restart after tick");
endmodule

// File: rtl/alc_gain_core.sv
module alc_gain_core import alc_pkg::*; #(
   parameter int TMR_W     = 16,
   parameter int INIT_GAIN = 23
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   strobe,
   input  logic                   active,
   input  logic                   at_target,
   input  logic                   over,
   input  logic [TMR_W-1:0]       hold_len,
   input  logic [TMR_W-1:0]       dcy_len,
   input  logic [TMR_W-1:0]       atk_len,
   input  logic [GAIN_CODE_W-1:0] ceiling,
   output logic [GAIN_CODE_W-1:0] loop_gain
);
   logic [GAIN_CODE_W-1:0] loop_q;
   logic [TMR_W-1:0]       hold_q;
   logic                   over_q, over_now;
   logic                   atk_tick, dcy_tick, step_dn, step_up, held;

   assign held     = (hold_q >= hold_len);
   assign over_now = over_q || over;
   assign step_dn  = atk_tick && over_now && (loop_q != '0);
   assign step_up  = dcy_tick && !step_dn && (loop_q < ceiling);

   alc_step_timer #(.CNT_W(TMR_W)) u_atk (
      .clk(clk), .rst_n(rst_n), .clr(!active), .adv(strobe && active),
      .len(atk_len), .tick(atk_tick));

   alc_step_timer #(.CNT_W(TMR_W)) u_dcy (
      .clk(clk), .rst_n(rst_n), .clr(!active || (strobe && at_target)),
      .adv(strobe && active && !at_target && held),
      .len(dcy_len), .tick(dcy_tick));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loop_q <= GAIN_CODE_W'(INIT_GAIN);
         hold_q <= '0;
         over_q <= 1'b0;
      end else if (!active) begin
         hold_q <= '0;
         over_q <= 1'b0;
      end else if (strobe) begin
         if (at_target)   hold_q <= '0;
         else if (!held)  hold_q <= hold_q + 1'b1;
         over_q <= atk_tick ? 1'b0 : over_now;
         if (step_dn)      loop_q <= loop_q - 1'b1;
         else if (step_up) loop_q <= loop_q + 1'b1;
      end
   end

   assign loop_gain = loop_q;

   p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_q > $past(loop_q)) |-> (loop_q <= $past(ceiling)))
      else $error("gain rose above ceiling");
   p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_q != $past(loop_q)) |->
      ((loop_q == $past(loop_q) + 1'b1) || (loop_q == $past(loop_q) - 1'b1)))
      else $error("gain moved by more than one code");
   p_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(loop_q) == '0) |-> (loop_q <= GAIN_CODE_W'(1)))
      else $error("gain wrapped below zero");
   p_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!active || !strobe) |=> $stable(loop_q))
      else $error("loop gain moved without an active strobe");
endmodule

// File: rtl/alc_zc_gate.sv
module alc_zc_gate import alc_pkg::*; #(
   parameter int ZC_TIMEOUT = 2048,
   parameter int INIT_GAIN  = 23
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   strobe,
   input  logic                   zc_en,
   input  logic                   sign_bit,
   input  logic [GAIN_CODE_W-1:0] loop_gain,
   output logic [GAIN_CODE_W-1:0] applied
);
   localparam int TMO_W = $clog2(ZC_TIMEOUT);

   logic [GAIN_CODE_W-1:0] applied_q;
   logic [TMO_W-1:0]       tmo_q;
   logic                   prev_sign_q, pending, crossed, expired;

   assign pending = (applied_q != loop_gain);
   assign crossed = (sign_bit != prev_sign_q);
   assign expired = (tmo_q == TMO_W'(ZC_TIMEOUT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         applied_q   <= GAIN_CODE_W'(INIT_GAIN);
         tmo_q       <= '0;
         prev_sign_q <= 1'b0;
      end else begin
         if (strobe) prev_sign_q <= sign_bit;
         if (!zc_en) begin
            applied_q <= loop_gain;
            tmo_q     <= '0;
         end else if (strobe) begin
            if (!pending) tmo_q <= '0;
            else if (crossed || expired) begin
               applied_q <= loop_gain;
               tmo_q     <= '0;
            end else tmo_q <= tmo_q + 1'b1;
         end
      end
   end

   assign applied = zc_en ? applied_q : loop_gain;

   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tmo_q) < ZC_TIMEOUT)
      else $error("zero-cross timeout counter overran");
   p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (zc_en && !strobe) |=> $stable(applied_q))
      else $error("gated gain changed without a strobe");
endmodule

// File: rtl/alc_engine.sv
module alc_engine import alc_pkg::*; #(
   parameter int SAMPLE_W    = 16,
   parameter int HOLD_UNIT   = 128,
   parameter int DECAY_UNIT  = 1152,
   parameter int ATTACK_UNIT = 288,
   parameter int ZC_TIMEOUT  = 2048,
   parameter int INIT_GAIN   = 23
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   smp_strobe,
   input  logic [SAMPLE_W-1:0]    smp_left,
   input  logic [SAMPLE_W-1:0]    smp_right,
   input  logic [1:0]             cfg_mode,
   input  logic                   cfg_zc_en,
   input  logic [2:0]             cfg_max_gain,
   input  logic [3:0]             cfg_target,
   input  logic [3:0]             cfg_hold,
   input  logic [3:0]             cfg_decay,
   input  logic [3:0]             cfg_attack,
   input  logic [GAIN_CODE_W-1:0] man_gain_left,
   input  logic [GAIN_CODE_W-1:0] man_gain_right,
   output logic [GAIN_CODE_W-1:0] gain_left,
   output logic [GAIN_CODE_W-1:0] gain_right
);
   localparam int TMR_W = timer_width(longint'(HOLD_UNIT) <<< 14,
                                      longint'(DECAY_UNIT) <<< 10,
                                      longint'(ATTACK_UNIT) <<< 10);
   localparam int PROD_W = SAMPLE_W + 16;
   localparam logic [SAMPLE_W-1:0] FULL_SCALE = {1'b0, {(SAMPLE_W-1){1'b1}}};

   if (SAMPLE_W < 8 || SAMPLE_W > 32) begin : g_bad_width
      $error("SAMPLE_W out of range");
   end
   if (HOLD_UNIT < 1 || DECAY_UNIT < 1 || ATTACK_UNIT < 1) begin : g_bad_unit
      $error("time units must be positive");
   end
   if (ZC_TIMEOUT < 2) begin : g_bad_tmo
      $error("ZC_TIMEOUT must be at least 2");
   end
   if (INIT_GAIN < 0 || INIT_GAIN > 63) begin : g_bad_init
      $error("INIT_GAIN outside gain code range");
   end

   alc_mode_e              mode;
   logic                   active, at_target, over, sign_bit;
   logic [PROD_W-1:0]      prod;
   logic [SAMPLE_W-1:0]    thr;
   logic [TMR_W-1:0]       hold_len, dcy_len, atk_len;
   logic [3:0]             dcy_sh, atk_sh;
   logic [GAIN_CODE_W-1:0] loop_gain, cur_gain;

   assign mode   = alc_mode_e'(cfg_mode);
   assign active = (mode != MODE_OFF);
   assign prod   = PROD_W'(FULL_SCALE) * PROD_W'(target_frac(cfg_target));
   assign thr    = prod[PROD_W-1:16];

   assign dcy_sh   = (cfg_decay  > 4'd10) ? 4'd10 : cfg_decay;
   assign atk_sh   = (cfg_attack > 4'd10) ? 4'd10 : cfg_attack;
   assign hold_len = (cfg_hold == 4'd0) ? '0 : (TMR_W'(HOLD_UNIT) << (cfg_hold - 4'd1));
   assign dcy_len  = TMR_W'(DECAY_UNIT) << dcy_sh;
   assign atk_len  = TMR_W'(ATTACK_UNIT) << atk_sh;

   alc_level_detect #(.SAMPLE_W(SAMPLE_W)) u_lvl (
      .smp_l(smp_left), .smp_r(smp_right), .mode(mode), .thr(thr),
      .at_target(at_target), .over(over), .sign_bit(sign_bit));

   alc_gain_core #(.TMR_W(TMR_W), .INIT_GAIN(INIT_GAIN)) u_core (
      .clk(clk), .rst_n(rst_n), .strobe(smp_strobe), .active(active),
      .at_target(at_target), .over(over), .hold_len(hold_len),
      .dcy_len(dcy_len), .atk_len(atk_len),
      .ceiling(ceiling_code(cfg_max_gain)), .loop_gain(loop_gain));

   alc_zc_gate #(.ZC_TIMEOUT(ZC_TIMEOUT), .INIT_GAIN(INIT_GAIN)) u_zc (
      .clk(clk), .rst_n(rst_n), .strobe(smp_strobe && active), .zc_en(cfg_zc_en),
      .sign_bit(sign_bit), .loop_gain(loop_gain), .applied(cur_gain));

   // Channel 0 is left (driven by mode bit 1), channel 1 is right (mode bit 0).
   logic [GAIN_CODE_W-1:0] ch_out [2];
   for (genvar c = 0; c < 2; c++) begin : g_chan
      logic [GAIN_CODE_W-1:0] manual;
      assign manual    = (c == 0) ? man_gain_left : man_gain_right;
      assign ch_out[c] = cfg_mode[1-c] ? cur_gain : manual;
   end
   assign gain_left  = ch_out[0];
   assign gain_right = ch_out[1];

   p_manual_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'b00) |-> ((gain_left == man_gain_left) && (gain_right == man_gain_right)))
      else $error("loop gain leaked out while off");
endmodule

// File: tb/tb_alc_engine.sv
module tb_alc_engine;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic clk = 1'b0, rst_n = 1'b0, smp_strobe = 1'b0;
   logic [W-1:0] smp_left = '0, smp_right = '0;
   logic [1:0] cfg_mode = 2'b11;
   logic cfg_zc_en = 1'b0;
   logic [2:0] cfg_max_gain = 3'd7;
   logic [3:0] cfg_target = 4'd15, cfg_hold = 4'd0, cfg_decay = 4'd0, cfg_attack = 4'd0;
   logic [5:0] man_gain_left = 6'd5, man_gain_right = 6'd9;
   logic [5:0] gain_left, gain_right;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alc_engine #(.SAMPLE_W(W), .HOLD_UNIT(4), .DECAY_UNIT(8), .ATTACK_UNIT(2),
                .ZC_TIMEOUT(16), .INIT_GAIN(23)) dut (
      .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe), .smp_left(smp_left),
      .smp_right(smp_right), .cfg_mode(cfg_mode), .cfg_zc_en(cfg_zc_en),
      .cfg_max_gain(cfg_max_gain), .cfg_target(cfg_target), .cfg_hold(cfg_hold),
      .cfg_decay(cfg_decay), .cfg_attack(cfg_attack), .man_gain_left(man_gain_left),
      .man_gain_right(man_gain_right), .gain_left(gain_left), .gain_right(gain_right));

   typedef struct packed {
      logic [1:0]  mode;
      logic        zc;
      logic [2:0]  mg;
      logic [3:0]  tg, hd, dc, ak;
      logic [15:0] al, ar, n;
      logic [5:0]  el, er;
      logic [23:0] tag;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{2'd3, 1'b0, 3'd7, 4'd15, 4'd0,  4'd15, 4'd0,  16'd20000, 16'd20000, 16'd20,   6'd13, 6'd13, "R4 "},
      '{2'd3, 1'b0, 3'd7, 4'd15, 4'd15, 4'd15, 4'd1,  16'd20000, 16'd20000, 16'd20,   6'd18, 6'd18, "R4 "},
      '{2'd3, 1'b0, 3'd7, 4'd15, 4'd0,  4'd0,  4'd0,  16'd1000,  16'd1000,  16'd40,   6'd28, 6'd28, "R5 "},
      '{2'd3, 1'b0, 3'd7, 4'd15, 4'd2,  4'd0,  4'd0,  16'd1000,  16'd1000,  16'd40,   6'd27, 6'd27, "R5 "},
      '{2'd3, 1'b0, 3'd3, 4'd15, 4'd0,  4'd0,  4'd0,  16'd1000,  16'd1000,  16'd200,  6'd31, 6'd31, "R2 "},
      '{2'd3, 1'b0, 3'd7, 4'd15, 4'd15, 4'd15, 4'd0,  16'd20000, 16'd20000, 16'd100,  6'd0,  6'd0,  "R8 "},
      '{2'd3, 1'b0, 3'd7, 4'd15, 4'd0,  4'd15, 4'd0,  16'd1000,  16'd1000,  16'd8192, 6'd24, 6'd24, "R6 "},
      '{2'd3, 1'b0, 3'd7, 4'd15, 4'd0,  4'd9,  4'd0,  16'd1000,  16'd1000,  16'd8192, 6'd25, 6'd25, "R6 "},
      '{2'd3, 1'b0, 3'd7, 4'd15, 4'd15, 4'd15, 4'd15, 16'd20000, 16'd20000, 16'd2048, 6'd22, 6'd22, "R6 "},
      '{2'd1, 1'b0, 3'd7, 4'd15, 4'd15, 4'd15, 4'd0,  16'd20000, 16'd20000, 16'd20,   6'd5,  6'd13, "R1 "},
      '{2'd2, 1'b0, 3'd7, 4'd15, 4'd15, 4'd15, 4'd0,  16'd20000, 16'd20000, 16'd20,   6'd13, 6'd9,  "R1 "},
      '{2'd0, 1'b0, 3'd7, 4'd15, 4'd15, 4'd15, 4'd0,  16'd20000, 16'd20000, 16'd20,   6'd5,  6'd9,  "R1 "},
      '{2'd3, 1'b0, 3'd7, 4'd15, 4'd15, 4'd15, 4'd0,  16'd1000,  16'd20000, 16'd20,   6'd13, 6'd13, "R12"},
      '{2'd2, 1'b0, 3'd7, 4'd15, 4'd0,  4'd0,  4'd0,  16'd1000,  16'd20000, 16'd16,   6'd25, 6'd9,  "R1 "},
      '{2'd3, 1'b1, 3'd7, 4'd15, 4'd15, 4'd15, 4'd0,  16'd20000, 16'd20000, 16'd20,   6'd14, 6'd14, "R10"},
      '{2'd3, 1'b0, 3'd7, 4'd11, 4'd15, 4'd15, 4'd0,  16'd9000,  16'd9000,  16'd20,   6'd13, 6'd13, "R3 "},
      '{2'd3, 1'b0, 3'd7, 4'd11, 4'd0,  4'd0,  4'd0,  16'd8000,  16'd8000,  16'd16,   6'd25, 6'd25, "R3 "}
   };

   task automatic check(input string tag, input string what, input logic [5:0] act, input logic [5:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      smp_strobe = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send(input logic [W-1:0] l, input logic [W-1:0] r);
      smp_left   = l;
      smp_right  = r;
      smp_strobe = 1'b1;
      @(negedge clk);
      smp_strobe = 1'b0;
      @(negedge clk);
   endtask

   task automatic burst(input logic [15:0] al, input logic [15:0] ar, input int n);
      for (int k = 1; k <= n; k++) begin
         if (k % 2 == 1) send(al, ar);
         else send(-al, -ar);
      end
   endtask

   task automatic setup(input logic [1:0] m, input logic z, input logic [3:0] t,
                        input logic [3:0] h, input logic [3:0] d, input logic [3:0] a);
      cfg_mode = m; cfg_zc_en = z; cfg_max_gain = 3'd7;
      cfg_target = t; cfg_hold = h; cfg_decay = d; cfg_attack = a;
      do_reset();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R13: reset value on both outputs
      setup(2'd3, 1'b0, 4'd15, 4'd15, 4'd15, 4'd0);
      check("R13", "reset left", gain_left, 6'd23);
      check("R13", "reset right", gain_right, 6'd23);

      // Vector table: sign alternates every strobe, starting positive
      for (int i = 0; i < NV; i++) begin
         cfg_mode = VECS[i].mode; cfg_zc_en = VECS[i].zc; cfg_max_gain = VECS[i].mg;
         cfg_target = VECS[i].tg; cfg_hold = VECS[i].hd; cfg_decay = VECS[i].dc;
         cfg_attack = VECS[i].ak;
         do_reset();
         burst(VECS[i].al, VECS[i].ar, int'(VECS[i].n));
         check(string'(VECS[i].tag), $sformatf("vector %0d left", i), gain_left, VECS[i].el);
         check(string'(VECS[i].tag), $sformatf("vector %0d right", i), gain_right, VECS[i].er);
      end

      // R9: zero-cross off, change visible right after the strobe edge
      setup(2'd3, 1'b0, 4'd15, 4'd15, 4'd15, 4'd0);
      send(16'd20000, 16'd20000);
      check("R9", "before attack tick", gain_left, 6'd23);
      send(16'd20000, 16'd20000);
      check("R9", "at attack tick", gain_left, 6'd22);

      // R3/R7: exactly at threshold (16422) is not over
      setup(2'd3, 1'b0, 4'd15, 4'd15, 4'd15, 4'd0);
      send(16'd16422, 16'd16422);
      send(16'd1000, 16'd1000);
      check("R7", "equal sample not over", gain_left, 6'd23);
      setup(2'd3, 1'b0, 4'd15, 4'd15, 4'd15, 4'd0);
      send(16'd16423, 16'd16423);
      send(16'd1000, 16'd1000);
      check("R3", "one above threshold is over", gain_left, 6'd22);

      // R7: equal sample restarts hold (H=8, D=8)
      setup(2'd3, 1'b0, 4'd15, 4'd2, 4'd0, 4'd0);
      for (int k = 0; k < 12; k++) send(16'd1000, 16'd1000);
      check("R7", "before restart", gain_left, 6'd23);
      send(16'd16422, 16'd16422);
      for (int k = 0; k < 16; k++) send(16'd1000, 16'd1000);
      check("R7", "after restart", gain_left, 6'd24);

      // R1: off mode freezes loop; turning on shows untouched loop gain
      setup(2'd0, 1'b0, 4'd15, 4'd15, 4'd15, 4'd0);
      burst(16'd20000, 16'd20000, 20);
      cfg_mode = 2'd3;
      @(negedge clk);
      check("R1", "loop frozen while off", gain_left, 6'd23);

      // R10: DC input holds change until a sign change
      setup(2'd3, 1'b1, 4'd15, 4'd0, 4'd0, 4'd0);
      for (int k = 0; k < 10; k++) send(16'd1000, 16'd1000);
      check("R10", "no crossing yet", gain_left, 6'd23);
      send(-16'd1000, -16'd1000);
      check("R10", "applied on crossing", gain_left, 6'd24);

      // R11: DC input, timeout after 16 pending strobes
      setup(2'd3, 1'b1, 4'd15, 4'd0, 4'd0, 4'd0);
      for (int k = 0; k < 23; k++) send(16'd1000, 16'd1000);
      check("R11", "before timeout", gain_right, 6'd23);
      send(16'd1000, 16'd1000);
      check("R11", "at timeout", gain_right, 6'd25);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule